// File: doc/BRIEF.md
# Booth Multiply-Accumulate with Rounding

This block multiplies two signed 16-bit fractions and adds a third signed 16-bit fraction to the product, returning one rounded and saturated 16-bit fraction. All three operands and the result are Q1.15 values. The multiplier recodes the multiplier operand into radix-4 signed digits, one digit per bit pair. The resulting rows are compressed by a tree of 3:2 carry-save adders. The product leaves the core as a sum vector and a carry vector, and no carry-propagate adder is used in the core.

A register stage holds the two redundant vectors and the addend. The accumulate stage then merges these three operands with one carry-save level. A rounding constant of half a result LSB is placed in the empty low bits of the addend row. One carry-propagate adder completes the sum, and the result is clamped to the 16-bit range. Operands enter through a valid/ready pair and results leave through a second valid/ready pair. A second register holds the result. Up to two operations can be in flight, and one operation is accepted per cycle when the output is not stalled.

Top module: `booth_mac`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: For operands accepted with `in_valid_i && in_ready_o` at a rising edge, the result is computed as follows. Take the two's-complement integers a, b and c. Form t = a*b + c*2^15 + 2^14. The result is floor(t / 2^15), clamped to [-32768, 32767].
- R3: A result above 32767 saturates to 32767. Example: a = b = -32768 with c = 0 gives 32767.
- R4: A result below -32768 saturates to -32768. Example: a = -32768, b = 32767, c = -32768 gives -32768.
- R5: A value lying exactly halfway between two result codes rounds toward plus infinity. Example: 1 × 16384 gives 1, and -1 × 16384 gives 0.
- R6: Suppose an operation is accepted at edge k into an empty pipeline, with `out_ready_i` held at 1. Then `out_valid_o` is still 0 after edge k and is 1 after edge k+1.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` and `result_o` stay unchanged.
- R8: When both stages hold data and the output is stalled, `in_ready_o` is 0. Results come out in acceptance order, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand set is valid |
| in_ready_o | output | 1 | Block can take an operand set |
| mcand_i | input | 16 | Multiplicand, Q1.15 |
| mplier_i | input | 16 | Multiplier, Q1.15, Booth-recoded |
| addend_i | input | 16 | Addend, Q1.15 |
| out_valid_o | output | 1 | Result is valid |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 16 | Rounded, saturated Q1.15 result |

## Verification
A result is due two rising edges after its operands are accepted, provided the output is not stalled. Each stalled cycle at the output moves it later by one edge. The bench keeps a queue of expected values that it pushes at each observed input handshake and pops at each observed output handshake, so timing shifts caused by back-pressure cannot misalign the comparison. Inputs change just after a rising edge and all handshakes and outputs are sampled at the falling edge. The exact latency and the hold behaviour are then checked on the specific falling edges where an output change is or is not allowed.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_sel_t;

  // vectors left after l levels of 3:2 compression of m operands
  function automatic int vec_cnt(int m, int l);
    int n;
    n = m;
    for (int i = 0; i < l; i++) n = n - n / 3;
    return n;
  endfunction

  function automatic int num_levels(int m);
    int n;
    int l;
    n = m;
    l = 0;
    while (n > 2) begin
      n = n - n / 3;
      l++;
    end
    return l;
  endfunction

  // behavioural round-half-up and clamp, used by checks only
  function automatic longint ref_round_sat(longint total, int frac, int n);
    longint v;
    longint hi;
    longint lo;
    v  = (total + (longint'(1) <<< (frac - 1))) >>> frac;
    hi = (longint'(1) <<< (n - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) v = hi;
    if (v < lo) v = lo;
    return v;
  endfunction

endpackage

// File: rtl/mac_csa3.sv
module mac_csa3 #(
  parameter int W = 34
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  assign sum_o = x_i ^ y_i ^ z_i;
  assign carry_o[0] = 1'b0;
  assign carry_o[W-1:1] = (x_i[W-2:0] & y_i[W-2:0]) |
                          (y_i[W-2:0] & z_i[W-2:0]) |
                          (x_i[W-2:0] & z_i[W-2:0]);
endmodule

// File: rtl/mac_booth_row.sv
module mac_booth_row
  import mac_pkg::*;
#(
  parameter int N     = 16,
  parameter int W     = 34,
  parameter int SHIFT = 0
) (
  input  logic [N-1:0] mcand_i,
  input  logic [2:0]   trip_i,
  output logic [W-1:0] row_o,
  output logic         inv_o
);
  booth_sel_t  sel;
  logic [W-1:0] a_ext;
  logic [W-1:0] mag;

  // radix-4 digit from bits {b[2i+1], b[2i], b[2i-1]}
  assign sel.neg = trip_i[2] & ~(trip_i[1] & trip_i[0]);
  assign sel.one = trip_i[1] ^ trip_i[0];
  assign sel.two = (trip_i[2] & ~trip_i[1] & ~trip_i[0]) |
                   (~trip_i[2] & trip_i[1] & trip_i[0]);

  assign a_ext = {{(W-N){mcand_i[N-1]}}, mcand_i};

  always_comb begin
    if (sel.two)      mag = a_ext << 1;
    else if (sel.one) mag = a_ext;
    else              mag = '0;
  end

  // ones' complement here; the +1 enters the tree through inv_o
  assign row_o = (sel.neg ? ~mag : mag) << SHIFT;
  assign inv_o = sel.neg;
endmodule

// File: rtl/mac_mul_core.sv
module mac_mul_core
  import mac_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 34
) (
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  localparam int ROWS = N / 2;
  localparam int M    = ROWS + 1;
  localparam int NL   = num_levels(M);

  logic [N:0]      b_ext;
  logic [ROWS-1:0] inv;
  logic [W-1:0]    inv_vec;
  logic [W-1:0]    lvl [0:NL][0:M-1];

  assign b_ext = {mplier_i, 1'b0};

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    mac_booth_row #(.N(N), .W(W), .SHIFT(2*i)) i_row (
      .mcand_i (mcand_i),
      .trip_i  (b_ext[2*i+2:2*i]),
      .row_o   (lvl[0][i]),
      .inv_o   (inv[i])
    );
  end

  always_comb begin
    inv_vec = '0;
    for (int i = 0; i < ROWS; i++) inv_vec[2*i] = inv[i];
  end
  assign lvl[0][ROWS] = inv_vec;

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    localparam int CN = vec_cnt(M, l);
    localparam int G  = CN / 3;
    for (genvar k = 0; k < G; k++) begin : g_csa
      mac_csa3 #(.W(W)) i_csa (
        .x_i     (lvl[l][3*k]),
        .y_i     (lvl[l][3*k+1]),
        .z_i     (lvl[l][3*k+2]),
        .sum_o   (lvl[l+1][2*k]),
        .carry_o (lvl[l+1][2*k+1])
      );
    end
    for (genvar j = 3*G; j < CN; j++) begin : g_pass
      assign lvl[l+1][2*G + j - 3*G] = lvl[l][j];
    end
    for (genvar j = CN - G; j < M; j++) begin : g_zero
      assign lvl[l+1][j] = '0;
    end
  end

  assign sum_o   = lvl[NL][0];
  assign carry_o = lvl[NL][1];
endmodule

// File: rtl/mac_acc_add.sv
module mac_acc_add #(
  parameter int N = 16,
  parameter int W = 34
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] carry_i,
  input  logic [N-1:0] addend_i,
  output logic [N-1:0] result_o
);
  localparam int FR = N - 1;
  localparam logic [N-1:0] POS_MAX = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] NEG_MAX = {1'b1, {(N-1){1'b0}}};

  logic [W-1:0]  add_vec;
  logic [W-1:0]  s3;
  logic [W-1:0]  c3;
  logic [W-1:0]  total;
  logic [W-FR-1:0] hi;
  logic          ovf;

  // addend lands at bit FR; its zero low bits carry the half-LSB round constant
  assign add_vec = ({{(W-N){addend_i[N-1]}}, addend_i} << FR) | (W'(1) << (FR - 1));

  mac_csa3 #(.W(W)) i_csa (
    .x_i     (sum_i),
    .y_i     (carry_i),
    .z_i     (add_vec),
    .sum_o   (s3),
    .carry_o (c3)
  );

  assign total = s3 + c3;
  assign hi    = total[W-1:FR];
  assign ovf   = ~((&hi[W-FR-1:N-1]) | ~(|hi[W-FR-1:N-1]));

  always_comb begin
    if (ovf) result_o = hi[W-FR-1] ? NEG_MAX : POS_MAX;
    else     result_o = hi[N-1:0];
  end
endmodule

// File: rtl/booth_mac.sv
module booth_mac
  import mac_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  input  logic [N-1:0] addend_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [N-1:0] result_o
);
  localparam int W = 2 * N + 2;

  logic [W-1:0] core_sum;
  logic [W-1:0] core_carry;
  logic         s1_v_q;
  logic [W-1:0] s1_sum_q;
  logic [W-1:0] s1_carry_q;
  logic [N-1:0] s1_add_q;
  logic         out_v_q;
  logic [N-1:0] res_q;
  logic [N-1:0] acc_res;
  logic         s2_ready;
  logic         s1_adv;

  mac_mul_core #(.N(N), .W(W)) i_core (
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .sum_o    (core_sum),
    .carry_o  (core_carry)
  );

  assign s2_ready   = ~out_v_q | out_ready_i;
  assign s1_adv     = ~s1_v_q | s2_ready;
  assign in_ready_o = s1_adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q     <= 1'b0;
      s1_sum_q   <= '0;
      s1_carry_q <= '0;
      s1_add_q   <= '0;
    end else if (s1_adv) begin
      s1_v_q <= in_valid_i;
      if (in_valid_i) begin
        s1_sum_q   <= core_sum;
        s1_carry_q <= core_carry;
        s1_add_q   <= addend_i;
      end
    end
  end

  mac_acc_add #(.N(N), .W(W)) i_acc (
    .sum_i    (s1_sum_q),
    .carry_i  (s1_carry_q),
    .addend_i (s1_add_q),
    .result_o (acc_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q <= 1'b0;
      res_q   <= '0;
    end else if (s2_ready) begin
      out_v_q <= s1_v_q;
      if (s1_v_q) res_q <= acc_res;
    end
  end

  assign out_valid_o = out_v_q;
  assign result_o    = res_q;

  // R2
  prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |->
      (core_sum + core_carry) ==
      ($signed({{(W-N){mcand_i[N-1]}}, mcand_i}) * $signed({{(W-N){mplier_i[N-1]}}, mplier_i})));

  // R2
  acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_v_q && s2_ready) |=>
      longint'($signed(result_o)) ==
      $past(ref_round_sat(longint'($signed(s1_sum_q + s1_carry_q)) +
                          (longint'($signed(s1_add_q)) <<< (N - 1)), N - 1, N)));

  // R6
  lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_v_q && s2_ready) |=> out_valid_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o)));

  // R8
  full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_v_q && out_valid_o && !out_ready_i) |-> !in_ready_o);

  // R8
  s1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_v_q && !s2_ready) |=> (s1_v_q && $stable(s1_sum_q) && $stable(s1_carry_q)));
endmodule

// File: tb/test_booth_mac.sv
module test_booth_mac;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [N-1:0] a = '0;
  logic signed [N-1:0] b = '0;
  logic signed [N-1:0] c = '0;
  logic in_ready;
  logic out_valid;
  logic [N-1:0] res;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  int acc_cnt = 0;
  bit use_lit = 1'b0;
  int lit_val = 0;
  string cur_tag = "R2";
  int cyc = 0;

  always #5 clk = ~clk;

  booth_mac #(.N(N)) i_booth_mac (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .mcand_i     (a),
    .mplier_i    (b),
    .addend_i    (c),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .result_o    (res)
  );

  function automatic int ref_mac(int x, int y, int z);
    longint t;
    t = longint'(x) * longint'(y) + (longint'(z) <<< 15) + 64'sd16384;
    t = t >>> 15;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return int'(t);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: handshakes sampled mid-cycle, take effect at next rising edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 extra result", $signed(res), 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check($signed(res) == e, t, $signed(res), e);
        end
      end
      if (in_valid && in_ready) begin
        acc_cnt++;
        exp_q.push_back(use_lit ? lit_val : ref_mac(a, b, c));
        tag_q.push_back(cur_tag);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic send(int x, int y, int z, bit lit, int lv, string tag);
    a = N'(x); b = N'(y); c = N'(z);
    use_lit = lit; lit_val = lv; cur_tag = tag;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    use_lit = 1'b0;
    cur_tag = "R2";
  endtask

  task automatic drain();
    out_ready = 1'b1;
    do @(negedge clk); while (exp_q.size() != 0 || out_valid);
    @(posedge clk); #1;
  endtask

  function automatic int pick();
    case ($urandom % 8)
      0: return -32768;
      1: return 32767;
      2: return 0;
      3: return -1;
      4: return 1;
      default: return $signed(16'($urandom));
    endcase
  endfunction

  initial begin
    int held;
    int base;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    out_ready = 1'b1;
    send(-32768, -32768, 0, 1'b1, 32767, "R3 pos sat");
    send(32767, 32767, 32767, 1'b1, 32767, "R3 pos sat addend");
    send(-32768, 32767, -32768, 1'b1, -32768, "R4 neg sat");
    send(-32768, -32768, -32768, 1'b1, 0, "R4 no sat at -1+1");
    send(1, 16384, 0, 1'b1, 1, "R5 positive tie");
    send(-1, 16384, 0, 1'b1, 0, "R5 negative tie");
    send(3, 16384, 0, 1'b1, 2, "R5 tie 1.5");
    send(-3, 16384, 0, 1'b1, -1, "R5 tie -1.5");
    send(32767, -32768, 0, 1'b1, -32767, "R2 near min");
    send(16384, 16384, 100, 1'b1, 8292, "R2 half squared plus addend");
    drain();

    // R6 exact latency
    a = 16'sd1000; b = 16'sd2000; c = -16'sd5;
    cur_tag = "R6 result"; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R6 accept", in_ready, 1);
    @(posedge clk); #1;
    in_valid = 1'b0; cur_tag = "R2";
    @(negedge clk);
    check(out_valid == 1'b0, "R6 not yet valid", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R6 valid two edges later", out_valid, 1);
    drain();

    // R7 hold under stall
    out_ready = 1'b0;
    send(-12345, 23456, 777, 1'b0, 0, "R7 stalled result");
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b1, "R7 valid while stalled", out_valid, 1);
    held = $signed(res);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R7 valid held", out_valid, 1);
      check($signed(res) == held, "R7 result held", $signed(res), held);
    end
    drain();

    // R8 back-pressure fills both stages
    out_ready = 1'b0;
    base = acc_cnt;
    a = 16'sd300; b = -16'sd400; c = 16'sd50; cur_tag = "R8 queued";
    in_valid = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R8 ready low when full", in_ready, 0);
    check(acc_cnt - base == 2, "R8 accepted count", acc_cnt - base, 2);
    @(posedge clk); #1;
    in_valid = 1'b0; cur_tag = "R2";
    drain();

    // R2 random traffic with back-pressure
    in_valid = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      bit fired;
      @(negedge clk);
      fired = in_valid && in_ready;
      @(posedge clk); #1;
      if (fired || !in_valid) begin
        in_valid = ($urandom % 4) != 0;
        a = N'(pick()); b = N'(pick()); c = N'(pick());
      end
      out_ready = ($urandom % 3) != 0;
    end
    @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    drain();
    check(exp_q.size() == 0, "R8 nothing left", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule